// File: doc/BRIEF.md
# Clock Mode Decoder and Divider Tree

This block is the digital control core of a multi-output system clock generator. One source clock feeds it. A 3-bit mode word, an active-low test input and an active-low APIC rate strap select what seven output groups do. The groups are CPU, half-CPU, 66 MHz class, 33 MHz class, 48 MHz, reference and APIC. For each group the block emits a clock-enable pulse train (`tick_o`), which is one source-clock cycle high once every N cycles, and a per-group output enable (`oe_o`) for the pad tri-state control. It also drives `pll48_en_o`, which turns the separate 48 MHz synthesis path on or off.

In the run modes the source clock is the master clock, and each group divides it by a parameterised ratio. The CPU ratio depends on the selected rate. The half-CPU group always divides by twice the CPU ratio. In the test mode the source clock is the external test clock, and every group divides it by a fixed power of two. The block decodes its inputs into a configuration and registers it. Whenever that registered configuration changes, every divider restarts, so all groups come back phase-aligned on the same source-clock cycle.

With the default ratios and a 400 MHz master clock, the outputs are as follows. The CPU group runs at 100 or 133.3 MHz, and the half-CPU group at 50 or 66.7 MHz. The fixed groups give about 66.7, 33.3, 50 and 14.3 MHz. The APIC group gives one quarter of the CPU rate or a fixed 16.67 MHz.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: When `test_n` is 0, or `mode_sel` is 3'b000, every bit of `oe_o` and every bit of `tick_o` is 0 from the cycle after the inputs are captured, and `pll48_en_o` is 0.
- R2: The codes 3'b001 and 3'b101 on `mode_sel` behave exactly like 3'b000: all enables and ticks are 0.
- R3: In the run modes (`mode_sel` 3'b010, 3'b011, 3'b110 or 3'b111, with `test_n`=1), `oe_o` is 7'h7F. `mode_sel[2]` selects the CPU rate. With `mode_sel[2]`=0, the CPU group (index 0) ticks every DIV_CPU_LO=4 cycles. With `mode_sel[2]`=1, it ticks every DIV_CPU_HI=3 cycles. Three groups tick at fixed intervals in the run modes: the 66 MHz group (index 2) every DIV_M66=6 cycles, the 33 MHz group (index 3) every DIV_M33=12 cycles and the reference group (index 5) every DIV_REF=28 cycles.
- R4: The half-CPU group (index 1) ticks every 2×(CPU ratio) cycles in the run modes. Each of its ticks coincides with a CPU tick in every mode.
- R5: `mode_sel` 3'b011 and 3'b111 set `pll48_en_o`=1, and the 48 MHz group (index 4) ticks every DIV_F48=8 cycles. With 3'b010 and 3'b110, `pll48_en_o`=0, and tick 4 is held at 0 while `oe_o[4]` stays 1.
- R6: In a run mode with `apic_fixed_n`=1, the APIC group (index 6) ticks every 4×(CPU ratio) cycles, and each of its ticks coincides with a CPU tick.
- R7: In a run mode with `apic_fixed_n`=0, the APIC group ticks every DIV_APIC_FIX=24 cycles, whatever the CPU rate.
- R8: `mode_sel`=3'b100 with `test_n`=1 is the test mode. `oe_o` is 7'h7F and `pll48_en_o` is 0. Groups 0 to 6 tick every 2, 4, 4, 8, 2, 1 and 16 cycles.
- R9: The configuration is the mode decoded from `mode_sel` and `test_n`, plus `apic_fixed_n` in the run modes only. The block captures a changed configuration on a clock edge. In the first cycle after that edge, every enabled group ticks, and its count restarts from there. A capture that leaves the configuration unchanged does not disturb the count.
- R10: While `rst_n` is 0, `tick_o`, `oe_o` and `pll48_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock (master clock in run modes, test clock in test mode) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode word {rate select, select 1, select 0} |
| apic_fixed_n | input | 1 | APIC rate strap; 0 selects the fixed APIC rate |
| test_n | input | 1 | Active-low test input; 0 tri-states all groups |
| tick_o | output | 7 | Per-group clock-enable pulses, index 0 CPU to 6 APIC |
| oe_o | output | 7 | Per-group output enables |
| pll48_en_o | output | 1 | Enable for the 48 MHz synthesis path |

## Verification
Each of the eight mode codes is held for a long stretch with both strap settings. This distinguishes the two CPU ratios, the strap-driven APIC ratios, the gated and the live 48 MHz path, and the reserved codes from the true run codes. Mode changes on every cycle show whether the dividers realign on each configuration change. Strap toggles during test mode show that a change which leaves the configuration unchanged does not restart the count. Random sequences of modes, strap values and occasional low `test_n`, with random hold lengths, catch stale counts carried across changes and a low test input that fails to take priority.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [1:0] {
        OP_OFF  = 2'd0,
        OP_RUN  = 2'd1,
        OP_TEST = 2'd2
    } op_e;

    typedef struct packed {
        op_e  op;
        logic rate_hi;
        logic f48_on;
        logic apic_fix;
    } cfg_t;

    localparam cfg_t CFG_OFF = '{OP_OFF, 1'b0, 1'b0, 1'b0};

    localparam int NGRP     = 7;
    localparam int GRP_CPU  = 0;
    localparam int GRP_HALF = 1;
    localparam int GRP_M66  = 2;
    localparam int GRP_M33  = 3;
    localparam int GRP_F48  = 4;
    localparam int GRP_REF  = 5;
    localparam int GRP_APIC = 6;

    // fixed test-mode division ratios
    localparam int TST_CPU  = 2;
    localparam int TST_HALF = 4;
    localparam int TST_M66  = 4;
    localparam int TST_M33  = 8;
    localparam int TST_F48  = 2;
    localparam int TST_REF  = 1;
    localparam int TST_APIC = 16;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/clkgen_mode_decode.sv
module clkgen_mode_decode
    import clkgen_pkg::*;
(
    input  logic [2:0] mode_sel,
    input  logic       apic_fixed_n,
    input  logic       test_n,
    output cfg_t       cfg
);

    always_comb begin
        cfg = CFG_OFF;
        if (test_n) begin
            unique case (mode_sel)
                3'b010, 3'b011, 3'b110, 3'b111: begin
                    cfg.op       = OP_RUN;
                    cfg.rate_hi  = mode_sel[2];
                    cfg.f48_on   = mode_sel[0];
                    cfg.apic_fix = ~apic_fixed_n;
                end
                3'b100:  cfg.op = OP_TEST;
                default: cfg    = CFG_OFF;   // 000, 001, 101
            endcase
        end
    end

endmodule

// File: rtl/clkgen_div_cnt.sv
module clkgen_div_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] ratio,
    output logic             tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (restart) begin
            div_d.cnt = '0;
        end else if ({1'b0, div_q.cnt} + 1'b1 >= {1'b0, ratio}) begin
            div_d.cnt = '0;
        end else begin
            div_d.cnt = div_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign tick = (div_q.cnt == '0);

endmodule

// File: rtl/clkgen_out_gate.sv
module clkgen_out_gate
    import clkgen_pkg::*;
(
    input  op_e             op,
    input  logic            f48_on,
    input  logic [NGRP-1:0] raw_tick,
    output logic [NGRP-1:0] tick_o,
    output logic [NGRP-1:0] oe_o,
    output logic            pll48_en_o
);

    always_comb begin
        tick_o     = '0;
        oe_o       = '0;
        pll48_en_o = 1'b0;
        unique case (op)
            OP_RUN: begin
                oe_o            = '1;
                tick_o          = raw_tick;
                tick_o[GRP_F48] = raw_tick[GRP_F48] & f48_on;
                pll48_en_o      = f48_on;
            end
            OP_TEST: begin
                oe_o   = '1;
                tick_o = raw_tick;
            end
            default: begin
                tick_o = '0;
                oe_o   = '0;
            end
        endcase
    end

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkgen_pkg::*;
#(
    parameter int DIV_CPU_LO   = 4,
    parameter int DIV_CPU_HI   = 3,
    parameter int DIV_M66      = 6,
    parameter int DIV_M33      = 12,
    parameter int DIV_F48      = 8,
    parameter int DIV_REF      = 28,
    parameter int DIV_APIC_FIX = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      mode_sel,
    input  logic            apic_fixed_n,
    input  logic            test_n,
    output logic [NGRP-1:0] tick_o,
    output logic [NGRP-1:0] oe_o,
    output logic            pll48_en_o
);

    localparam int MAX_CPU = max2(DIV_CPU_LO, DIV_CPU_HI);
    localparam int MAX_RUN = max2(max2(4 * MAX_CPU, DIV_APIC_FIX),
                                  max2(max2(DIV_M66, DIV_M33), max2(DIV_F48, DIV_REF)));
    localparam int MAX_DIV = max2(MAX_RUN, TST_APIC);
    localparam int CNT_W   = $clog2(MAX_DIV + 1);

    typedef struct packed {
        cfg_t cfg;
    } ctl_t;

    ctl_t                       ctl_d, ctl_q;
    cfg_t                       cfg_in;
    logic                       restart;
    logic [NGRP-1:0][CNT_W-1:0] ratio;
    logic [NGRP-1:0]            raw_tick;

    clkgen_mode_decode u_dec (
        .mode_sel     (mode_sel),
        .apic_fixed_n (apic_fixed_n),
        .test_n       (test_n),
        .cfg          (cfg_in)
    );

    always_comb begin
        int cpu_r;
        ctl_d     = ctl_q;
        ctl_d.cfg = cfg_in;
        restart   = (cfg_in != ctl_q.cfg);

        cpu_r = ctl_q.cfg.rate_hi ? DIV_CPU_HI : DIV_CPU_LO;
        ratio = '0;
        unique case (ctl_q.cfg.op)
            OP_RUN: begin
                ratio[GRP_CPU]  = CNT_W'(cpu_r);
                ratio[GRP_HALF] = CNT_W'(2 * cpu_r);
                ratio[GRP_M66]  = CNT_W'(DIV_M66);
                ratio[GRP_M33]  = CNT_W'(DIV_M33);
                ratio[GRP_F48]  = CNT_W'(DIV_F48);
                ratio[GRP_REF]  = CNT_W'(DIV_REF);
                ratio[GRP_APIC] = ctl_q.cfg.apic_fix ? CNT_W'(DIV_APIC_FIX)
                                                     : CNT_W'(4 * cpu_r);
            end
            OP_TEST: begin
                ratio[GRP_CPU]  = CNT_W'(TST_CPU);
                ratio[GRP_HALF] = CNT_W'(TST_HALF);
                ratio[GRP_M66]  = CNT_W'(TST_M66);
                ratio[GRP_M33]  = CNT_W'(TST_M33);
                ratio[GRP_F48]  = CNT_W'(TST_F48);
                ratio[GRP_REF]  = CNT_W'(TST_REF);
                ratio[GRP_APIC] = CNT_W'(TST_APIC);
            end
            default: begin
                for (int g = 0; g < NGRP; g++) begin
                    ratio[g] = CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{cfg: CFG_OFF};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_div
        clkgen_div_cnt #(
            .CNT_W (CNT_W)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .ratio   (ratio[g]),
            .tick    (raw_tick[g])
        );
    end

    clkgen_out_gate u_gate (
        .op         (ctl_q.cfg.op),
        .f48_on     (ctl_q.cfg.f48_on),
        .raw_tick   (raw_tick),
        .tick_o     (tick_o),
        .oe_o       (oe_o),
        .pll48_en_o (pll48_en_o)
    );

endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk
    import clkgen_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [2:0]      mode_sel,
    input logic            apic_fixed_n,
    input logic            test_n,
    input logic [NGRP-1:0] tick_o,
    input logic [NGRP-1:0] oe_o,
    input logic            pll48_en_o
);

    assert_test_low_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !test_n |=> (oe_o == '0 && tick_o == '0 && !pll48_en_o));

    assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (test_n && (mode_sel == 3'b001 || mode_sel == 3'b101)) |=> (oe_o == '0 && tick_o == '0));

    assert_half_on_cpu_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[GRP_HALF] |-> tick_o[GRP_CPU]);

    assert_f48_held_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_n && (mode_sel == 3'b010 || mode_sel == 3'b110))
        |=> (!tick_o[GRP_F48] && oe_o[GRP_F48] && !pll48_en_o));

    assert_apic_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_n && mode_sel[1] && apic_fixed_n) |=> (!tick_o[GRP_APIC] || tick_o[GRP_CPU]));

    assert_test_mode_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (test_n && mode_sel == 3'b100) |=> (tick_o[GRP_REF] && oe_o == '1 && !pll48_en_o));

    assert_restart_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll48_en_o) |-> (tick_o[GRP_CPU] && tick_o[GRP_F48] && tick_o[GRP_APIC]));

endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk u_chk (.*);

// File: tb/clkgen_mode_ctrl_test.sv
module clkgen_mode_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] mode_sel;
    logic       apic_fixed_n;
    logic       test_n;
    logic [6:0] tick_o;
    logic [6:0] oe_o;
    logic       pll48_en_o;

    always #10 clk = ~clk;   // 50 MHz

    clkgen_mode_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sel     (mode_sel),
        .apic_fixed_n (apic_fixed_n),
        .test_n       (test_n),
        .tick_o       (tick_o),
        .oe_o         (oe_o),
        .pll48_en_o   (pll48_en_o)
    );

    int checks = 0;
    int errors = 0;
    int bcode  = 0;
    int bk     = 0;
    bit done   = 0;

    // code = op*8 + rate*4 + f48*2 + fix ; op 0 off, 1 run, 2 test
    function automatic int enc(input logic [2:0] m, input logic s_n, input logic t_n);
        if (!t_n) return 0;
        case (m)
            3'b010: return 8 + 0 + 0 + (s_n ? 0 : 1);
            3'b011: return 8 + 0 + 2 + (s_n ? 0 : 1);
            3'b110: return 8 + 4 + 0 + (s_n ? 0 : 1);
            3'b111: return 8 + 4 + 2 + (s_n ? 0 : 1);
            3'b100: return 16;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_ratio(input int g, input int code);
        int cpu;
        if ((code >> 3) == 2) begin
            case (g)
                0: return 2;  1: return 4;  2: return 4;  3: return 8;
                4: return 2;  5: return 1;  default: return 16;
            endcase
        end
        cpu = ((code >> 2) & 1) ? 3 : 4;
        case (g)
            0: return cpu;
            1: return 2 * cpu;
            2: return 6;
            3: return 12;
            4: return 8;
            5: return 28;
            default: return (code & 1) ? 24 : 4 * cpu;
        endcase
    endfunction

    function automatic bit exp_tick(input int g, input int code, input int k);
        int op;
        op = code >> 3;
        if (op == 0) return 1'b0;
        if (op == 1 && g == 4 && ((code >> 1) & 1) == 0) return 1'b0;
        return (k % exp_ratio(g, code)) == 0;
    endfunction

    function automatic string tag_of(input int g, input int code, input int k, input logic [2:0] m);
        int op;
        op = code >> 3;
        if (op == 0) return (m == 3'b001 || m == 3'b101) ? "R2" : "R1";
        if (op == 2) return "R8";
        if (k == 0) return "R9";
        case (g)
            1: return "R4";
            4: return "R5";
            6: return (code & 1) ? "R7" : "R6";
            default: return "R3";
        endcase
    endfunction

    task automatic check_bit(input string tag, input string what, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0b expected %0b (mode %b strap %b test %b k %0d)",
                     tag, what, act, exp, mode_sel, apic_fixed_n, test_n, bk);
        end
    endtask

    task automatic check_outputs();
        int op;
        op = bcode >> 3;
        for (int g = 0; g < 7; g++) begin
            check_bit(tag_of(g, bcode, bk, mode_sel), $sformatf("tick[%0d]", g),
                      tick_o[g], exp_tick(g, bcode, bk));
        end
        checks++;
        if (oe_o !== ((op != 0) ? 7'h7F : 7'h00)) begin
            errors++;
            $display("FAIL %s oe actual %h expected %h", tag_of(0, bcode, 1, mode_sel),
                     oe_o, (op != 0) ? 7'h7F : 7'h00);
        end
        check_bit((op == 1) ? "R5" : tag_of(0, bcode, 1, mode_sel), "pll48_en",
                  pll48_en_o, (op == 1) && ((bcode >> 1) & 1));
    endtask

    // called at a falling edge: drive, take one rising edge, check at next falling edge
    task automatic step(input logic [2:0] m, input logic s_n, input logic t_n);
        int code;
        mode_sel     = m;
        apic_fixed_n = s_n;
        test_n       = t_n;
        @(posedge clk);
        code = enc(m, s_n, t_n);
        if (code != bcode) begin
            bcode = code;
            bk    = 0;
        end else begin
            bk++;
        end
        @(negedge clk);
        check_outputs();
    endtask

    task automatic hold(input logic [2:0] m, input logic s_n, input logic t_n, input int n);
        for (int i = 0; i < n; i++) step(m, s_n, t_n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1234_5EED);
        rst_n        = 1'b0;
        mode_sel     = 3'b111;
        apic_fixed_n = 1'b1;
        test_n       = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state with run inputs applied
        check_bit("R10", "tick any", |tick_o, 1'b0);
        check_bit("R10", "oe any", |oe_o, 1'b0);
        check_bit("R10", "pll48_en", pll48_en_o, 1'b0);
        mode_sel = 3'b000;
        rst_n    = 1'b1;
        bcode    = 0;
        bk       = 0;

        // directed: every mode code with both strap settings
        for (int m = 0; m < 8; m++) begin
            hold(3'(m), 1'b1, 1'b1, 50);
            hold(3'(m), 1'b0, 1'b1, 50);
        end
        // R1: test input low overrides run and test codes
        hold(3'b111, 1'b1, 1'b0, 20);
        hold(3'b100, 1'b1, 1'b0, 20);
        // R9: change every cycle
        for (int i = 0; i < 12; i++) step((i % 2) ? 3'b011 : 3'b110, 1'(i % 3 == 0), 1'b1);
        // R9: strap toggling in run restarts, in test mode it does not
        hold(3'b010, 1'b1, 1'b1, 7);
        hold(3'b010, 1'b0, 1'b1, 7);
        hold(3'b100, 1'b1, 1'b1, 5);
        hold(3'b100, 1'b0, 1'b1, 20);
        // R2: reserved to off does not restart anything visible
        hold(3'b001, 1'b1, 1'b1, 5);
        hold(3'b000, 1'b1, 1'b1, 5);
        hold(3'b101, 1'b0, 1'b1, 5);

        // random segments
        for (int s = 0; s < 400; s++) begin
            logic [2:0] m;
            logic       sn;
            logic       tn;
            int         len;
            m   = 3'($urandom_range(0, 7));
            sn  = 1'($urandom_range(0, 1));
            tn  = ($urandom_range(0, 7) != 0);
            len = $urandom_range(1, 64);
            hold(m, sn, tn, len);
        end
        finish_run();
    end

endmodule